// File: doc/BRIEF.md
# Quad DAC Parallel Write Sequencer

This block sits between a host-side request port and the parallel write bus of an external four-channel 8-bit voltage-output DAC. The DAC's channel latch is open while its active-low write strobe is low, and it captures the data bus on the strobe's rising edge. The address and data must therefore stay still for the whole low phase, and they must also respect setup, hold and pulse-width minimums. The sequencer turns each accepted request into a complete bus cycle. The cycle has three phases: address and data driven with the strobe high, strobe low, then a hold phase with the strobe high again. Every phase length is a cycle count rounded up from nanosecond minimums at the configured clock period.

A request carries a channel index and an 8-bit code. A request can also ask for a burst, which rewrites all four channels in ascending order. A burst takes its codes from a shadow bank. Each single write refreshes that bank for its own channel. A readback copy of the last code written to each channel is presented as one flat vector. In unipolar use the analog output of a channel is code/256 of full scale. Code 128 is half scale and code 255 is the top step.

Top module: `qdac_wr_seq`

## Requirements
- R1: The address bus carries the target channel: 00 for A, 01 for B, 10 for C, 11 for D. A single write to channel n drives dac_addr = n for its entire bus cycle.
- R2: A request is not taken while the sequencer is busy, and nothing happens while req_valid is low. In both cases the strobe stays high and the address, data and readback outputs keep their values, whatever req_chan, req_code and req_burst carry.
- R3: Each strobe-low pulse lasts exactly LOW_CYC clocks. LOW_CYC is the larger of ceil(WR_NS/CLK_NS) and ceil(DS_NS/CLK_NS), which is 14 at the defaults (5 ns clock, 50 ns width, 70 ns data setup).
- R4: Address and data appear SETUP_CYC clocks before the strobe falls and stay constant through the low phase. They also hold for HOLD_CYC clocks after the rise. SETUP_CYC is max(1, ceil(AS_NS/CLK_NS)) and HOLD_CYC is max(1, ceil(max(DH_NS,AH_NS)/CLK_NS)), which gives 1 and 2 at the defaults.
- R5: A burst request (req_burst = 1) writes channels 0, 1, 2 and 3 in that order, using the shadow codes. A single write (req_burst = 0) stores its code in the shadow entry of its channel.
- R6: req_ready is low from the cycle after acceptance until the final hold phase ends. It is high again in the cycle that carries done, so a request can be taken there.
- R7: busy is high from the cycle after acceptance through the last hold cycle, and the strobe is never low while busy is low.
- R8: done is high for exactly one clock, in the cycle right after the final hold phase of a single write or a burst.
- R9: rb_codes[8*n+7:8*n] holds the last code written to channel n. It updates in the cycle after that channel's hold phase ends.
- R10: After reset the strobe is high, the address and data buses are zero, all readback fields are zero and all shadow entries are zero, so a burst issued first writes code 0 to every channel.
- R11: Within a burst, the strobe stays high for at least one clock between consecutive low pulses (HOLD_CYC + SETUP_CYC clocks at the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_burst | input | 1 | 1: refresh all channels from the shadow bank; 0: single write |
| req_chan | input | 2 | Target channel for a single write |
| req_code | input | 8 | Code for a single write |
| dac_addr | output | 2 | Channel address to the DAC |
| dac_data | output | 8 | Data bus to the DAC |
| dac_wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | A bus cycle or burst is in progress |
| done | output | 1 | One-clock pulse after the final hold phase |
| rb_codes | output | 32 | Readback of the last code written, 8 bits per channel, channel 0 in the low byte |

## Verification
The assertions watch every clock for these properties:
- address and data keep still while the strobe is low and in the first cycle after it rises;
- each low pulse is exactly LOW_CYC long, counted by a run-length counter in the checker;
- the strobe stays high for at least one clock after each rise;
- the strobe falls only while busy is high;
- done lasts one clock and always follows the end of a hold phase.

Other behaviour only shows up in the bench's scenarios, which compare every output against a behavioural model on every clock. These cover the channel order and shadow codes of a burst, readback timing, zeros in the shadow after reset, requests that are ignored while busy, and a request accepted in the done cycle.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_LOW   = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  // clocks needed to cover a duration, rounded up
  function automatic int ns_to_cyc(input int dur_ns, input int clk_ns);
    return (dur_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int setup_cycles(input int as_ns, input int clk_ns);
    return max_int(1, ns_to_cyc(as_ns, clk_ns));
  endfunction

  // strobe-low length covers pulse width and data setup to the rising edge
  function automatic int low_cycles(input int wr_ns, input int ds_ns, input int clk_ns);
    return max_int(1, max_int(ns_to_cyc(wr_ns, clk_ns), ns_to_cyc(ds_ns, clk_ns)));
  endfunction

  function automatic int hold_cycles(input int dh_ns, input int ah_ns, input int clk_ns);
    return max_int(1, ns_to_cyc(max_int(dh_ns, ah_ns), clk_ns));
  endfunction

endpackage

// File: rtl/qdac_phase_timer.sv
module qdac_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/qdac_code_bank.sv
module qdac_code_bank #(
  parameter int CH = 4,
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sh_we,
  input  logic [AW-1:0]    sh_widx,
  input  logic [DW-1:0]    sh_wdat,
  input  logic [AW-1:0]    sh_ridx,
  output logic [DW-1:0]    sh_rdat,
  input  logic             rb_we,
  input  logic [AW-1:0]    rb_widx,
  input  logic [DW-1:0]    rb_wdat,
  output logic [CH*DW-1:0] rb_flat
);

  logic [DW-1:0] shadow_q [CH];
  logic [DW-1:0] rdback_q [CH];

  for (genvar g = 0; g < CH; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q[g] <= '0;
        rdback_q[g] <= '0;
      end else begin
        if (sh_we && sh_widx == AW'(g)) shadow_q[g] <= sh_wdat;
        if (rb_we && rb_widx == AW'(g)) rdback_q[g] <= rb_wdat;
      end
    end
    assign rb_flat[g*DW +: DW] = rdback_q[g];
  end

  assign sh_rdat = shadow_q[sh_ridx];

endmodule

// File: rtl/qdac_wr_seq.sv
module qdac_wr_seq
  import qdac_pkg::*;
#(
  parameter int CLK_NS = 5,
  parameter int WR_NS  = 50,
  parameter int DS_NS  = 70,
  parameter int DH_NS  = 10,
  parameter int AS_NS  = 0,
  parameter int AH_NS  = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_burst,
  input  logic [1:0]  req_chan,
  input  logic [7:0]  req_code,
  output logic [1:0]  dac_addr,
  output logic [7:0]  dac_data,
  output logic        dac_wr_n,
  output logic        busy,
  output logic        done,
  output logic [31:0] rb_codes
);

  localparam int CH        = 4;
  localparam int AW        = 2;
  localparam int DW        = 8;
  localparam int SETUP_CYC = setup_cycles(AS_NS, CLK_NS);
  localparam int LOW_CYC   = low_cycles(WR_NS, DS_NS, CLK_NS);
  localparam int HOLD_CYC  = hold_cycles(DH_NS, AH_NS, CLK_NS);
  localparam int MAX_CYC   = max_int(SETUP_CYC, max_int(LOW_CYC, HOLD_CYC));
  localparam int CW        = $clog2(MAX_CYC + 1);

  phase_e         phase;
  logic           burst_q;
  logic           accept;
  logic           phase_end;
  logic           more_chan;
  logic           bus_cycle_end;
  logic           t_load;
  logic [CW-1:0]  t_val;
  logic [AW-1:0]  sh_ridx;
  logic [DW-1:0]  sh_rdat;

  assign accept        = req_valid && (phase == PH_IDLE);
  assign more_chan     = burst_q && (dac_addr != AW'(CH - 1));
  assign bus_cycle_end = (phase == PH_HOLD) && phase_end;
  assign t_load        = accept || ((phase != PH_IDLE) && phase_end);
  assign sh_ridx       = (phase == PH_IDLE) ? '0 : dac_addr + 1'b1;

  always_comb begin
    unique case (phase)
      PH_SETUP: t_val = CW'(LOW_CYC - 1);
      PH_LOW:   t_val = CW'(HOLD_CYC - 1);
      default:  t_val = CW'(SETUP_CYC - 1);
    endcase
  end

  qdac_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (phase_end)
  );

  qdac_code_bank #(.CH(CH), .AW(AW), .DW(DW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .sh_we   (accept && !req_burst),
    .sh_widx (req_chan),
    .sh_wdat (req_code),
    .sh_ridx (sh_ridx),
    .sh_rdat (sh_rdat),
    .rb_we   (bus_cycle_end),
    .rb_widx (dac_addr),
    .rb_wdat (dac_data),
    .rb_flat (rb_codes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      burst_q  <= 1'b0;
      dac_addr <= '0;
      dac_data <= '0;
      dac_wr_n <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase    <= PH_SETUP;
          burst_q  <= req_burst;
          dac_addr <= req_burst ? '0 : req_chan;
          dac_data <= req_burst ? sh_rdat : req_code;
        end
        PH_SETUP: if (phase_end) begin
          phase    <= PH_LOW;
          dac_wr_n <= 1'b0;
        end
        PH_LOW: if (phase_end) begin
          phase    <= PH_HOLD;
          dac_wr_n <= 1'b1;
        end
        PH_HOLD: if (phase_end) begin
          if (more_chan) begin
            phase    <= PH_SETUP;
            dac_addr <= dac_addr + 1'b1;
            dac_data <= sh_rdat;
          end else begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (phase != PH_IDLE);
  assign req_ready = (phase == PH_IDLE);

endmodule

// File: rtl/qdac_wr_seq_chk.sv
module qdac_wr_seq_chk
  import qdac_pkg::*;
#(
  parameter int CLK_NS = 5,
  parameter int WR_NS  = 50,
  parameter int DS_NS  = 70
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] dac_addr,
  input logic [7:0] dac_data,
  input logic       dac_wr_n,
  input logic       busy,
  input logic       done,
  input logic       bus_cycle_end
);

  localparam int LOW_CYC = low_cycles(WR_NS, DS_NS, CLK_NS);

  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= '0;
    else if (!dac_wr_n) low_run <= low_run + 1'b1;
    else low_run <= '0;
  end

  p_bus_still_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_wr_n && $past(!dac_wr_n)) |-> ($stable(dac_addr) && $stable(dac_data)));

  p_bus_hold_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> ($stable(dac_addr) && $stable(dac_data)));

  p_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_wr_n && low_run != '0) |-> (low_run == 16'(LOW_CYC)));

  p_strobe_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |=> dac_wr_n);

  p_strobe_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> busy);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bus_cycle_end) && !busy));

endmodule

bind qdac_wr_seq qdac_wr_seq_chk #(
  .CLK_NS (CLK_NS),
  .WR_NS  (WR_NS),
  .DS_NS  (DS_NS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dac_addr      (dac_addr),
  .dac_data      (dac_data),
  .dac_wr_n      (dac_wr_n),
  .busy          (busy),
  .done          (done),
  .bus_cycle_end (bus_cycle_end)
);

// File: tb/tb_qdac_wr_seq.sv
`timescale 1ns/1ps
module tb_qdac_wr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_burst = 1'b0;
  logic [1:0]  req_chan = '0;
  logic [7:0]  req_code = '0;
  logic        req_ready, dac_wr_n, busy, done;
  logic [1:0]  dac_addr;
  logic [7:0]  dac_data;
  logic [31:0] rb_codes;

  always #2.5 clk = ~clk;

  qdac_wr_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_burst(req_burst), .req_chan(req_chan), .req_code(req_code),
    .dac_addr(dac_addr), .dac_data(dac_data), .dac_wr_n(dac_wr_n),
    .busy(busy), .done(done), .rb_codes(rb_codes)
  );

  // timing in clocks, worked out from the ns minimums at a 5 ns clock
  int n_setup, n_low, n_hold;
  initial begin
    n_setup = 1;                          // 0 ns address setup, one clock minimum
    n_low = 0;
    while (n_low * 5 < 70 || n_low * 5 < 50) n_low++;
    n_hold = 0;
    while (n_hold * 5 < 10) n_hold++;
  end

  // expected vector: {done, busy, wr_n, addr[1:0], data[7:0], rb[31:0]}
  logic [44:0] expq[$];
  logic [44:0] cur;
  logic [7:0]  m_sh [4];
  logic [7:0]  m_rb [4];
  logic [1:0]  m_addr;
  logic [7:0]  m_data;
  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  function automatic logic [31:0] rb_now();
    return {m_rb[3], m_rb[2], m_rb[1], m_rb[0]};
  endfunction

  task automatic plan_write(input logic [1:0] ch, input logic [7:0] code);
    for (int i = 0; i < n_setup; i++) expq.push_back({1'b0, 1'b1, 1'b1, ch, code, rb_now()});
    for (int i = 0; i < n_low;   i++) expq.push_back({1'b0, 1'b1, 1'b0, ch, code, rb_now()});
    for (int i = 0; i < n_hold;  i++) expq.push_back({1'b0, 1'b1, 1'b1, ch, code, rb_now()});
    m_rb[ch] = code;
    m_addr = ch;
    m_data = code;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      expq.delete();
      for (int i = 0; i < 4; i++) begin m_sh[i] = '0; m_rb[i] = '0; end
      m_addr = '0;
      m_data = '0;
      cur = {1'b0, 1'b0, 1'b1, 2'b00, 8'h00, 32'h0};
    end else begin
      if (req_valid && !cur[43]) begin
        if (req_burst) begin
          for (int c = 0; c < 4; c++) plan_write(2'(c), m_sh[c]);
        end else begin
          m_sh[req_chan] = req_code;
          plan_write(req_chan, req_code);
        end
        expq.push_back({1'b1, 1'b0, 1'b1, m_addr, m_data, rb_now()});
      end
      if (expq.size() > 0) cur = expq.pop_front();
      else cur = {1'b0, 1'b0, 1'b1, m_addr, m_data, rb_now()};
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      if (dac_wr_n !== cur[42]) begin
        miscompares++;
        $display("FAIL R3/R11 strobe: actual %b expected %b at %0t", dac_wr_n, cur[42], $time);
      end
      if (dac_addr !== cur[41:40]) begin
        miscompares++;
        $display("FAIL R1/R5 addr: actual %0d expected %0d at %0t", dac_addr, cur[41:40], $time);
      end
      if (dac_data !== cur[39:32]) begin
        miscompares++;
        $display("FAIL R4/R5 data: actual %h expected %h at %0t", dac_data, cur[39:32], $time);
      end
      if (busy !== cur[43]) begin
        miscompares++;
        $display("FAIL R7 busy: actual %b expected %b at %0t", busy, cur[43], $time);
      end
      if (req_ready !== !cur[43]) begin
        miscompares++;
        $display("FAIL R6 ready: actual %b expected %b at %0t", req_ready, !cur[43], $time);
      end
      if (done !== cur[44]) begin
        miscompares++;
        $display("FAIL R8 done: actual %b expected %b at %0t", done, cur[44], $time);
      end
      if (rb_codes !== cur[31:0]) begin
        miscompares++;
        $display("FAIL R9/R10 readback: actual %h expected %h at %0t", rb_codes, cur[31:0], $time);
      end
    end
  end

  task automatic send(input logic burst, input logic [1:0] ch, input logic [7:0] code);
    @(negedge clk);
    req_valid = 1'b1; req_burst = burst; req_chan = ch; req_code = code;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;                         // R10 reset values compared from here on
    repeat (3) @(negedge clk);
    send(1'b1, 2'd0, 8'h00); wait_idle(); // R10: zero shadow, R5 order
    send(1'b0, 2'd3, 8'hFF); wait_idle(); // R1 top code on channel D
    send(1'b0, 2'd2, 8'h80); wait_idle(); // half scale on C
    send(1'b0, 2'd0, 8'h5A); wait_idle();
    send(1'b0, 2'd1, 8'h01); wait_idle();
    // R2: inputs toggle with valid low while idle
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); req_chan = 2'(i); req_code = 8'(i * 37); req_burst = i[0];
    end
    // R2: valid pulses while busy are ignored
    send(1'b0, 2'd2, 8'hC3);
    @(negedge clk); req_valid = 1'b1; req_chan = 2'd1; req_code = 8'h77; req_burst = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    send(1'b1, 2'd0, 8'h00); wait_idle(); // R5 burst from shadow, R11 gaps
    // R6: request held through done is taken in the done cycle
    @(negedge clk);
    req_valid = 1'b1; req_burst = 1'b0; req_chan = 2'd1; req_code = 8'hA5;
    @(negedge clk);
    while (!done) @(negedge clk);
    req_code = 8'h3C; req_chan = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    send(1'b1, 2'd0, 8'h00); wait_idle();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule